// File: doc/BRIEF.md
# Halt and bus-release controller

This block lives beside the sequencer of a small 8-bit processor core and decides when instruction execution freezes because an external, active-low halt request is asserted. Every machine cycle has a phase-1 tick and a phase-2 tick, each marked by a one-clock enable. The request is synchronised to the clock and then tested only once per instruction, at the phase-1 tick of that instruction's last machine cycle. A request seen there stops the core once that instruction has ended. A request that arrives too late for that test lets one further whole instruction run.

While the core is halted the block drops the output enable used by the address, data and read/write pad drivers, and it forces the valid-memory-address strobe low. After a fixed number of clocks it raises a bus-available flag, so an external master knows it may use the bus. Releasing the request restarts the core at a phase-2 tick: the pads are driven again and bus-available falls on the same edge, and the next machine cycle is the opcode fetch of the following instruction. Non-maskable and maskable interrupt requests that arrive during the halt are held inside the block. They are shown to the core only once it runs again.

Top module: `halt_bus_ctrl`

## Requirements
- R1: During and directly after reset, `bus_oe` is 1, `ba` is 0, `stall` is 0, `vma` equals `core_vma`, and `nmi_req` and `irq_req` are 0.
- R2: Suppose `halt_n` is low at the clock edge two edges before the phase-1 tick (`ph1_en`=1) of a machine cycle with `last_cyc`=1. Then `bus_oe` falls and `stall` rises on that cycle's phase-2 tick edge, so the halt follows that instruction.
- R3: Suppose `halt_n` first goes low later than R2 allows, down to the edge just before that phase-1 tick or during the phase-2 half of that cycle. Then the current instruction and one more complete instruction run before the halt takes effect.
- R4: While halted (`bus_oe`=0), `stall` is 1, `vma` is 0 whatever `core_vma` is, and no instruction completes.
- R5: `ba` rises exactly BA_DLY clocks after `bus_oe` falls, and `ba` is never 1 while `bus_oe` is 1.
- R6: `ba` is 0 whenever the core is executing.
- R7: After `halt_n` returns high, the block resumes at a phase-2 tick edge. On that edge `bus_oe` rises, and `ba` and `stall` fall. The next machine cycle is the opcode fetch of the following instruction.
- R8: A falling edge on `nmi_n` is latched. `nmi_req` stays 0 while halted and is 1 from the resume edge until a one-clock `nmi_ack`.
- R9: If `irq_n` is low at any time during a halt, this is held even after `irq_n` returns high. `irq_req` stays 0 while halted and is 1 after resume until a one-clock `irq_ack`. While running with nothing held, `irq_req` follows the synchronised inverse of `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ph1_en | input | 1 | One-clock phase-1 tick of the current machine cycle |
| ph2_en | input | 1 | One-clock phase-2 tick; ends the machine cycle |
| halt_n | input | 1 | Asynchronous active-low halt request (level) |
| last_cyc | input | 1 | High for the whole last machine cycle of an instruction |
| core_vma | input | 1 | Valid-memory-address strobe from the core |
| nmi_n | input | 1 | Asynchronous non-maskable interrupt, falling-edge active |
| irq_n | input | 1 | Asynchronous maskable interrupt, level active-low |
| nmi_ack | input | 1 | Core has taken the pending non-maskable request |
| irq_ack | input | 1 | Core has taken the held maskable request |
| stall | output | 1 | Freezes the core sequencer |
| bus_oe | output | 1 | Output enable for address, data and read/write pads |
| vma | output | 1 | Gated valid-memory-address strobe |
| ba | output | 1 | Bus available to an external master |
| nmi_req | output | 1 | Non-maskable request presented to the core |
| irq_req | output | 1 | Maskable request presented to the core |

## Verification
The properties take for granted that the phase-1 and phase-2 ticks alternate, each one clock long, and that `last_cyc` stays constant through a whole machine cycle. They also assume acknowledges are only given while the core runs. The bench produces the ticks from a free-running four-clock machine cycle. A small core model advances `last_cyc` only on phase-2 ticks while `stall` is low. Halt requests, interrupt pulses and acknowledges are changed one nanosecond after a falling clock edge, at phases the bench picks on purpose, so the two-edge setup boundary is hit from both sides.

// File: rtl/halt_pkg.sv
package halt_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_HALTED = 2'd2
  } seq_state_e;

  localparam int SIG_HALT = 0;
  localparam int SIG_NMI  = 1;
  localparam int SIG_IRQ  = 2;
  localparam int NUM_ASYNC = 3;

endpackage

// File: rtl/halt_sync.sv
module halt_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
      end
    end
  endgenerate

  // oldest stage is the synchronised value
  assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/halt_seq.sv
module halt_seq
  import halt_pkg::*;
#(
  parameter int BA_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ph1_en,
  input  logic ph2_en,
  input  logic last_cyc,
  input  logic halt_s_n,
  output logic halted,
  output logic ba
);

  localparam int             CW      = $clog2(BA_DLY + 2);
  localparam logic [CW-1:0]  CNT_TOP = CW'(BA_DLY);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] dly_q, dly_d;

  // next state: the request is tested only at phase 1 of a last cycle
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (ph1_en && last_cyc && !halt_s_n) state_d = ST_DRAIN;
      ST_DRAIN:  if (ph2_en)                          state_d = ST_HALTED;
      ST_HALTED: if (ph2_en && halt_s_n)              state_d = ST_RUN;
      default:                                        state_d = ST_RUN;
    endcase
  end

  // release timer: counts clocks spent halted, saturates at the delay
  always_comb begin
    if (state_q != ST_HALTED)  dly_d = '0;
    else if (dly_q != CNT_TOP) dly_d = dly_q + CW'(1);
    else                       dly_d = dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
    end
  end

  assign halted = (state_q == ST_HALTED);
  assign ba     = halted && (dly_q == CNT_TOP);

endmodule

// File: rtl/halt_int_hold.sv
module halt_int_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic halted,
  input  logic nmi_s_n,
  input  logic irq_s_n,
  input  logic nmi_ack,
  input  logic irq_ack,
  output logic nmi_req,
  output logic irq_req
);

  logic nmi_last_q;
  logic nmi_pend_q, nmi_pend_d;
  logic irq_held_q, irq_held_d;
  logic nmi_fall;

  assign nmi_fall = nmi_last_q && !nmi_s_n;

  always_comb begin
    if (nmi_fall)     nmi_pend_d = 1'b1;
    else if (nmi_ack) nmi_pend_d = 1'b0;
    else              nmi_pend_d = nmi_pend_q;
  end

  always_comb begin
    if (halted && !irq_s_n) irq_held_d = 1'b1;
    else if (irq_ack)       irq_held_d = 1'b0;
    else                    irq_held_d = irq_held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_last_q <= 1'b1;
      nmi_pend_q <= 1'b0;
      irq_held_q <= 1'b0;
    end else begin
      nmi_last_q <= nmi_s_n;
      nmi_pend_q <= nmi_pend_d;
      irq_held_q <= irq_held_d;
    end
  end

  // requests stay hidden from the core while it is frozen
  assign nmi_req = !halted && nmi_pend_q;
  assign irq_req = !halted && (irq_held_q || !irq_s_n);

endmodule

// File: rtl/halt_bus_ctrl.sv
module halt_bus_ctrl
  import halt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BA_DLY      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ph1_en,
  input  logic ph2_en,
  input  logic halt_n,
  input  logic last_cyc,
  input  logic core_vma,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic nmi_ack,
  input  logic irq_ack,
  output logic stall,
  output logic bus_oe,
  output logic vma,
  output logic ba,
  output logic nmi_req,
  output logic irq_req
);

  logic [NUM_ASYNC-1:0] async_raw;
  logic [NUM_ASYNC-1:0] async_s;
  logic                 halted;

  assign async_raw[SIG_HALT] = halt_n;
  assign async_raw[SIG_NMI]  = nmi_n;
  assign async_raw[SIG_IRQ]  = irq_n;

  halt_sync #(
    .WIDTH   (NUM_ASYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({NUM_ASYNC{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (async_raw),
    .q     (async_s)
  );

  halt_seq #(
    .BA_DLY (BA_DLY)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph1_en   (ph1_en),
    .ph2_en   (ph2_en),
    .last_cyc (last_cyc),
    .halt_s_n (async_s[SIG_HALT]),
    .halted   (halted),
    .ba       (ba)
  );

  halt_int_hold u_int (
    .clk     (clk),
    .rst_n   (rst_n),
    .halted  (halted),
    .nmi_s_n (async_s[SIG_NMI]),
    .irq_s_n (async_s[SIG_IRQ]),
    .nmi_ack (nmi_ack),
    .irq_ack (irq_ack),
    .nmi_req (nmi_req),
    .irq_req (irq_req)
  );

  assign stall  = halted;
  assign bus_oe = !halted;
  assign vma    = core_vma && !halted;

endmodule

// File: rtl/halt_bus_ctrl_chk.sv
module halt_bus_ctrl_chk #(
  parameter int BA_DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ph2_en,
  input logic last_cyc,
  input logic nmi_ack,
  input logic stall,
  input logic bus_oe,
  input logic vma,
  input logic ba,
  input logic nmi_req,
  input logic irq_req
);

  localparam int            CW      = $clog2(BA_DLY + 3);
  localparam logic [CW-1:0] CNT_SAT = CW'(BA_DLY + 1);

  logic [CW-1:0] off_cnt_q;

  // clocks since the pads were released, saturating past the delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 off_cnt_q <= '0;
    else if (bus_oe)            off_cnt_q <= '0;
    else if (off_cnt_q != CNT_SAT) off_cnt_q <= off_cnt_q + CW'(1);
  end

  assert_ba_only_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ba |-> !bus_oe);

  assert_ba_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ba) |-> (off_cnt_q == CW'(BA_DLY)));

  assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (stall && !vma));

  assert_run_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!stall && !ba));

  assert_enter_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> ($past(ph2_en) && $past(last_cyc)));

  assert_release_ph2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> ($past(ph2_en) && !ba && !stall));

  assert_int_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (!nmi_req && !irq_req));

  assert_nmi_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_ack) |=> (nmi_req || !bus_oe));

endmodule

bind halt_bus_ctrl halt_bus_ctrl_chk #(.BA_DLY(BA_DLY)) u_chk (.*);

// File: tb/test_halt_bus_ctrl.sv
module test_halt_bus_ctrl;

  localparam int BA_DLY = 2;

  logic clk = 1'b0;
  logic rst_n, ph1_en, ph2_en, halt_n, last_cyc, core_vma;
  logic nmi_n, irq_n, nmi_ack, irq_ack;
  logic stall, bus_oe, vma, ba, nmi_req, irq_req;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int cyc, mc, retired, halt_ret, ba_cnt;
  bit run_model = 0;
  logic stall_seen, oe_prev, ba_prev, ph2_was, exp_nmi, exp_irq;

  always #5 clk = ~clk;

  halt_bus_ctrl #(.SYNC_STAGES(2), .BA_DLY(BA_DLY)) i_halt_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .halt_n(halt_n), .last_cyc(last_cyc), .core_vma(core_vma),
    .nmi_n(nmi_n), .irq_n(irq_n), .nmi_ack(nmi_ack), .irq_ack(irq_ack),
    .stall(stall), .bus_oe(bus_oe), .vma(vma), .ba(ba),
    .nmi_req(nmi_req), .irq_req(irq_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // core model, phase generator and scoreboard monitor, all at the falling edge
  always @(negedge clk) begin
    if (run_model) begin
      ph2_was = ph2_en;
      if (ph2_en && !stall_seen) begin
        if (last_cyc) retired++;
        mc = (mc + 1) % 2;
      end
      stall_seen = stall;
      if (oe_prev && !bus_oe) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected halt", retired, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(retired == e, "R2/R3 instructions run before halt", retired, e);
        end
        check(stall == 1'b1, "R4 stall on halt", stall, 1);
        check(vma == 1'b0, "R4 vma forced low", vma, 0);
        check(ba == 1'b0, "R5 ba not yet high", ba, 0);
        halt_ret = retired;
        ba_cnt = 0;
      end else if (!bus_oe) begin
        ba_cnt++;
        if (ba && !ba_prev) check(ba_cnt == BA_DLY, "R5 ba delay", ba_cnt, BA_DLY);
      end
      if (!oe_prev && bus_oe) begin
        check(ba_prev == 1'b1, "R5 ba was high during halt", ba_prev, 1);
        check(ba == 1'b0, "R7 ba falls on resume", ba, 0);
        check(stall == 1'b0, "R7 stall falls on resume", stall, 0);
        check(ph2_was == 1'b1, "R7 resume at phase-2 tick", ph2_was, 1);
        check(mc == 0, "R7 next cycle is opcode fetch", mc, 0);
        check(retired == halt_ret, "R4 nothing completes while halted", retired, halt_ret);
        check(nmi_req == exp_nmi, "R8 nmi shown on resume", nmi_req, exp_nmi);
        check(irq_req == exp_irq, "R9 irq shown on resume", irq_req, exp_irq);
      end
      oe_prev = bus_oe;
      ba_prev = ba;
      cyc++;
      ph1_en = (cyc % 4 == 1);
      ph2_en = (cyc % 4 == 3);
      last_cyc = (mc == 1);
    end
  end

  task automatic halt_at(input int want_mc, input int want_ph, input int extra, input string req);
    do begin
      @(negedge clk); #1;
    end while (!(mc == want_mc && cyc % 4 == want_ph));
    check(ba == 1'b0, {req, " R6 ba low while running"}, ba, 0);
    exp_q.push_back(retired + extra);
    halt_n = 1'b0;
    while (bus_oe) @(negedge clk);
    #1;
  endtask

  task automatic release_halt();
    halt_n = 1'b1;
    while (!bus_oe) @(negedge clk);
    repeat (6) @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; ph1_en = 1'b0; ph2_en = 1'b0; halt_n = 1'b1; last_cyc = 1'b0;
    core_vma = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; nmi_ack = 1'b0; irq_ack = 1'b0;
    exp_nmi = 1'b0; exp_irq = 1'b0;
    cyc = 0; mc = 0; retired = 0; halt_ret = 0; ba_cnt = 0;
    stall_seen = 1'b0; oe_prev = 1'b1; ba_prev = 1'b0; ph2_was = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(bus_oe == 1'b1, "R1 bus_oe in reset", bus_oe, 1);
    check(ba == 1'b0, "R1 ba in reset", ba, 0);
    check(stall == 1'b0, "R1 stall in reset", stall, 0);
    check(vma == 1'b1, "R1 vma follows core", vma, 1);
    check(nmi_req == 1'b0 && irq_req == 1'b0, "R1 no requests", nmi_req + irq_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_model = 1;
    repeat (3) @(negedge clk);
    #1;
    check(bus_oe == 1'b1 && ba == 1'b0 && stall == 1'b0, "R1 state after reset", ba + stall, 0);
    repeat (12) @(negedge clk);

    // early request in the first cycle: halt after this instruction
    halt_at(0, 1, 1, "R2 early");
    repeat (12) @(negedge clk);
    release_halt();

    // exactly at the setup boundary: still after this instruction, with interrupts during halt
    halt_at(0, 3, 1, "R2 boundary");
    repeat (3) @(negedge clk); #1;
    nmi_n = 1'b0;
    repeat (4) @(negedge clk); #1;
    nmi_n = 1'b1; irq_n = 1'b0;
    repeat (4) @(negedge clk); #1;
    irq_n = 1'b1;
    repeat (6) @(negedge clk); #1;
    check(nmi_req == 1'b0, "R8 nmi hidden while halted", nmi_req, 0);
    check(irq_req == 1'b0, "R9 irq hidden while halted", irq_req, 0);
    check(vma == 1'b0, "R4 vma low with core_vma high", vma, 0);
    exp_nmi = 1'b1; exp_irq = 1'b1;
    release_halt();
    check(nmi_req == 1'b1, "R8 nmi held until ack", nmi_req, 1);
    check(irq_req == 1'b1, "R9 irq held until ack", irq_req, 1);
    nmi_ack = 1'b1; irq_ack = 1'b1;
    @(negedge clk); #1;
    nmi_ack = 1'b0; irq_ack = 1'b0;
    @(negedge clk); #1;
    check(nmi_req == 1'b0, "R8 nmi cleared by ack", nmi_req, 0);
    check(irq_req == 1'b0, "R9 irq cleared by ack", irq_req, 0);
    exp_nmi = 1'b0; exp_irq = 1'b0;

    // live maskable level while running
    irq_n = 1'b0;
    repeat (4) @(negedge clk); #1;
    check(irq_req == 1'b1, "R9 irq follows level", irq_req, 1);
    irq_n = 1'b1;
    repeat (4) @(negedge clk); #1;
    check(irq_req == 1'b0, "R9 irq follows level high", irq_req, 0);

    // one edge too late: one more instruction
    halt_at(1, 0, 2, "R3 one edge late");
    repeat (12) @(negedge clk);
    release_halt();

    // during phase 2 of the last cycle: one more instruction
    halt_at(1, 2, 2, "R3 phase-2");
    repeat (12) @(negedge clk);
    release_halt();

    check(exp_q.size() == 0, "R2 every expected halt observed", exp_q.size(), 0);
    check(vma == 1'b1 && ba == 1'b0, "R6 running after last release", ba, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule